// File: doc/BRIEF.md
# SPI Slave with Select-Abort Retry

This block is a serial peripheral slave. An external master drives the serial clock. The block shifts a word out on its data-out line and shifts one in on its data-in line at the same time. Bits travel most significant first, and each word is 8 or 16 bits long. The serial clock, data-in and select pins pass through two-flop synchronizers, and the block detects clock edges in the system clock domain. The serial clock must therefore run well below the system clock: each serial clock phase has to last at least three system clocks.

Host software reaches the block through a small register port. A write to the data address loads the transmit holding register, and a read from it returns the receive holding register. A control register holds the enable, clock polarity, clock phase, select gating and word width bits. A status register reports transmit-full, receive-full and a sticky overflow. Every completed word raises a one-cycle interrupt pulse.

When select gating is on, the block shifts only while the active-low select pin is low. Raising select in the middle of a word releases data-out at once and abandons the word. The abandoned word stays in the holding register and is sent again from its first bit the next time select goes low.

Top module: `spi_sel_slave`

## Requirements
- R1: Register addresses are 0 for data, 1 for control and 2 for status. A host write to address 0 loads the transmit holding register and sets transmit-full. A host read of address 0 returns the last accepted received word and clears receive-full.
- R2: Control bits are bit 0 enable, bit 1 clock idle level, bit 2 late phase, bit 3 select gating and bit 4 wide. The leading edge is the serial clock leaving its idle level. With late phase 0 the block samples data-in on leading edges and launches the next bit on trailing edges. With late phase 1 it launches on leading edges and samples on trailing edges. Words are 16 bits when wide is 1 and 8 bits otherwise, sent and received most significant bit first.
- R3: With select gating 0 the select pin has no effect: words are exchanged even while it is held high.
- R4: With select gating 1, serial clock edges that arrive while select is high neither receive bits nor complete a word.
- R5: Output-enable for data-out is 1 exactly when enable is 1 and either select gating is 0 or the select pin is low. It follows the raw select pin in the same cycle.
- R6: With select gating 1, raising select mid-word discards the partial word, and no receive or interrupt results from it. The held transmit word is then resent from its first bit on the next select-low period.
- R7: With select gating 0, transmit-full clears when the holding register is copied into the shift register between words, without any serial clock activity.
- R8: With select gating 1, transmit-full stays set through partial and aborted words and clears only when the word carrying that data has been fully shifted.
- R9: A control write with late phase 1 and select gating 0 is refused, and the control register keeps its previous value.
- R10: Status bits are bit 0 transmit-full, bit 1 receive-full and bit 2 overflow. If a word completes while receive-full is set, overflow is set and the new word is dropped. Overflow stays set until the host writes status with bit 2 set.
- R11: The interrupt output pulses high for exactly one cycle for each completed word, including a word that is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | One-cycle pulse per completed word |
| sck_pin | input | 1 | External serial clock |
| sdi_pin | input | 1 | Serial data in |
| ss_n_pin | input | 1 | Active-low select |
| sdo_pin | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for data-out; 0 means high impedance |

## Verification
On every cycle, the assertions check four things. The control register never holds the refused phase and gating combination. The bit counter stays inside the word length and returns to zero while select is high under gating. Transmit-full and overflow never drop without their clearing events. The interrupt never lasts two cycles. Only the bench scenarios can show the full data path: the exact bit order on data-out for every polarity, phase, gating and width combination, the word read back from the receive register, and the complete abort and retry sequence with its status values.

// File: rtl/spi_sel_pkg.sv
// Shared constants and types for the select-gated serial slave.
// Assumes a 2-bit register address and a 5-bit control field.
package spi_sel_pkg;
    localparam int DATA_W   = 16;
    localparam int NARROW_W = 8;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    // Control field, bit 4 down to bit 0.
    typedef struct packed {
        logic wide;
        logic sel_gate;
        logic late_ph;
        logic cpol;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_sel_sync.sv
// Two-flop synchronizer for a bundle of asynchronous pins.
// Assumes each bit is independent; the reset value is chosen per bit.
module spi_sel_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_sel_engine.sv
// Shift engine: detects serial clock edges on the synchronized clock,
// samples and launches bits by polarity and phase, counts bits, and
// handles select gating with abort and reload of the held word.
// Assumes each serial clock phase lasts at least three system clocks.
module spi_sel_engine
    import spi_sel_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          ss_s,
    input  logic [DW-1:0] tx_hold,
    input  logic          tx_full,
    output logic          sdo,
    output logic          take_hold,
    output logic          sent_hold,
    output logic          rx_push,
    output logic [DW-1:0] rx_word
);
    localparam int CW = $clog2(DW);
    localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

    logic          sck_q;
    logic [CW-1:0] cnt;
    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic          carry;
    logic          rise, fall, lead_e, trail_e, smp_e, lch_e;
    logic          gate_ok, at_end;
    logic [CW-1:0] last;
    logic [DW-1:0] shifted;

    // Previous synchronized clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Edge classification, gating and end-of-word detection.
    always_comb begin
        rise    = sck_s & ~sck_q;
        fall    = ~sck_s & sck_q;
        lead_e  = ctrl.cpol ? fall : rise;
        trail_e = ctrl.cpol ? rise : fall;
        smp_e   = ctrl.late_ph ? trail_e : lead_e;
        lch_e   = ctrl.late_ph ? lead_e : trail_e;
        gate_ok = ctrl.en & (~ctrl.sel_gate | ~ss_s);
        last    = ctrl.wide ? CW'(DW-1) : CW'(NW-1);
        at_end  = (cnt == last);
        shifted = {rx_sr[DW-2:0], sdi_s};
    end

    // Strobes towards the register block.
    always_comb begin
        rx_push   = gate_ok & smp_e & at_end;
        rx_word   = ctrl.wide ? shifted : (shifted & NMASK);
        sent_hold = rx_push & carry;
        take_hold = gate_ok & ~ctrl.sel_gate & (cnt == '0) & tx_full & ~smp_e;
        sdo       = ctrl.wide ? tx_sr[DW-1] : tx_sr[NW-1];
    end

    // Bit counter, shift registers and holding-register reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
            carry <= 1'b0;
        end else if (!ctrl.en) begin
            cnt   <= '0;
            tx_sr <= '0;
            carry <= 1'b0;
        end else if (!gate_ok) begin
            cnt   <= '0;
            tx_sr <= tx_full ? tx_hold : '0;
            carry <= tx_full;
        end else if (smp_e) begin
            rx_sr <= shifted;
            if (at_end) begin
                cnt   <= '0;
                tx_sr <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (lch_e && cnt != '0) begin
            tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end else if (cnt == '0) begin
            if (ctrl.sel_gate) begin
                tx_sr <= tx_full ? tx_hold : '0;
                carry <= tx_full;
            end else if (tx_full) begin
                tx_sr <= tx_hold;
            end
        end
    end

    // R2: the bit count never passes the last bit of the chosen width.
    assert_cnt_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (ctrl.wide ? CW'(DW-1) : CW'(NW-1)));

    // R6: select high under gating leaves no partial word behind.
    assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.sel_gate && ss_s) |=> (cnt == '0));
endmodule

// File: rtl/spi_sel_regs.sv
// Host register block: control, transmit and receive holding registers,
// status flags, overflow and the interrupt pulse.
// Assumes one host access per cycle; read data is combinational.
module spi_sel_regs
    import spi_sel_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     tx_hold,
    output logic              tx_full,
    input  logic              take_hold,
    input  logic              sent_hold,
    input  logic              rx_push,
    input  logic [DW-1:0]     rx_word,
    output logic              irq
);
    logic [DW-1:0] rx_hold;
    logic          rx_full;
    logic          ovf;
    logic          wr_data, wr_ctrl, wr_stat, rd_data, tx_clr;
    ctrl_t         ctrl_new;

    // Access decode and the transmit-full clearing condition.
    always_comb begin
        wr_data  = bus_wr & (bus_addr == A_DATA);
        wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
        wr_stat  = bus_wr & (bus_addr == A_STAT);
        rd_data  = bus_rd & (bus_addr == A_DATA);
        ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        tx_clr   = ctrl.sel_gate ? sent_hold : take_hold;
    end

    // Control register; refuses late phase without select gating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_ctrl && !(ctrl_new.late_ph && !ctrl_new.sel_gate))
            ctrl <= ctrl_new;
    end

    // Transmit holding register and its full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_full <= 1'b0;
        end else if (wr_data) begin
            tx_hold <= bus_wdata;
            tx_full <= 1'b1;
        end else if (tx_clr) begin
            tx_full <= 1'b0;
        end
    end

    // Receive holding register, full flag and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            if (wr_stat && bus_wdata[2])
                ovf <= 1'b0;
            if (rx_push) begin
                if (rx_full && !rd_data) begin
                    ovf <= 1'b1;
                end else begin
                    rx_hold <= rx_word;
                    rx_full <= 1'b1;
                end
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end
        end
    end

    // One-cycle interrupt per completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= rx_push;
    end

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = rx_hold;
            A_CTRL:  bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
            A_STAT:  bus_rdata = {{(DW-3){1'b0}}, ovf, rx_full, tx_full};
            default: bus_rdata = '0;
        endcase
    end

    // R9: the refused combination never reaches the control register.
    assert_legal_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.late_ph && !ctrl.sel_gate));

    // R8: under gating, transmit-full drops only when its word completes.
    assert_txfull_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sel_gate && tx_full && !sent_hold) |=> tx_full);

    // R10: overflow is sticky until a status write clears it.
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_stat && bus_wdata[2])) |=> ovf);

    // R11: the interrupt never lasts two cycles.
    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/spi_sel_slave.sv
// Top of the select-gated serial slave: synchronizes the pins, joins the
// shift engine to the host registers and drives data-out enable.
// Assumes data-out is tri-stated by the pad using sdo_oe.
module spi_sel_slave
    import spi_sel_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    input  logic              sck_pin,
    input  logic              sdi_pin,
    input  logic              ss_n_pin,
    output logic              sdo_pin,
    output logic              sdo_oe
);
    ctrl_t         ctrl;
    logic [2:0]    pins_s;
    logic [DW-1:0] tx_hold, rx_word;
    logic          tx_full, take_hold, sent_hold, rx_push;

    spi_sel_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ss_n_pin, sdi_pin, sck_pin}), .q(pins_s)
    );

    spi_sel_engine #(.DW(DW), .NW(NW)) u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .sck_s(pins_s[0]), .sdi_s(pins_s[1]), .ss_s(pins_s[2]),
        .tx_hold(tx_hold), .tx_full(tx_full), .sdo(sdo_pin),
        .take_hold(take_hold), .sent_hold(sent_hold),
        .rx_push(rx_push), .rx_word(rx_word)
    );

    spi_sel_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl(ctrl), .tx_hold(tx_hold), .tx_full(tx_full),
        .take_hold(take_hold), .sent_hold(sent_hold),
        .rx_push(rx_push), .rx_word(rx_word), .irq(irq)
    );

    // Data-out drive follows the raw select pin so release is immediate.
    assign sdo_oe = ctrl.en & (~ctrl.sel_gate | ~ss_n_pin);
endmodule

// File: tb/spi_sel_slave_tb.sv
// Sweep bench: acts as the serial master and the host, over all polarity,
// phase, gating and width combinations, plus abort, overflow and config cases.
module spi_sel_slave_tb;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        irq, sck_pin = 1'b0, sdi_pin = 1'b0, ss_n_pin = 1'b1;
    logic        sdo_pin, sdo_oe;

    int checks = 0, errors = 0, irq_cnt = 0;
    bit cpol = 0, cke = 0;

    spi_sel_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_pin(sck_pin), .sdi_pin(sdi_pin), .ss_n_pin(ss_n_pin),
        .sdo_pin(sdo_pin), .sdo_oe(sdo_oe)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic config_set(input bit cp, input bit ck, input bit sg, input bit wd);
        bwrite(2'd1, 16'h0);
        sck_pin = cp; cpol = cp; cke = ck;
        idle(6);
        bwrite(2'd1, {11'b0, wd, sg, ck, cp, 1'b1});
        idle(4);
    endtask

    task automatic xfer(input int nb, input logic [15:0] mw, input int w,
                        output logic [15:0] got);
        got = '0;
        for (int i = 0; i < nb; i++) begin
            if (!cke) begin
                sdi_pin = mw[w-1-i]; idle(H);
                got = {got[14:0], sdo_pin};
                sck_pin = ~cpol; idle(H); sck_pin = cpol;
            end else begin
                sck_pin = ~cpol; sdi_pin = mw[w-1-i]; idle(H);
                got = {got[14:0], sdo_pin};
                sck_pin = cpol; idle(H);
            end
        end
        idle(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd, got, tx, mw, mask;
        int w, i0;
        bit sg, ck;
        idle(4); rst_n = 1'b1; idle(2);

        // Reset state.
        bread(2'd2, rd); chk(rd == 16'h0, "R10 reset status", rd, 0);
        bread(2'd1, rd); chk(rd == 16'h0, "R2 reset ctrl", rd, 0);
        chk(sdo_oe == 1'b0, "R5 reset oe", sdo_oe, 0);
        chk(irq == 1'b0, "R11 reset irq", irq, 0);

        // Sweep: polarity x (phase, gating) x width x pattern.
        for (int cp = 0; cp < 2; cp++)
            for (int md = 0; md < 3; md++)
                for (int wd = 0; wd < 2; wd++)
                    for (int k = 0; k < 2; k++) begin
                        ck = (md == 2); sg = (md != 0);
                        w = wd ? 16 : 8;
                        mask = wd ? 16'hFFFF : 16'h00FF;
                        config_set(cp[0], ck, sg, wd[0]);
                        tx = (16'h5A3C ^ (16'(k) * 16'h1F07) ^ (16'(cp) * 16'h0C91) ^ (16'(md) * 16'h3311)) & mask;
                        mw = ((tx * 16'd3) + 16'h02B5) & mask;
                        i0 = irq_cnt;
                        bwrite(2'd0, tx); idle(6);
                        if (sg) begin ss_n_pin = 1'b0; idle(6); end
                        // R3: with gating off, ss_n stays high throughout.
                        xfer(w, mw, w, got);
                        ss_n_pin = 1'b1; idle(4);
                        chk((got & mask) == tx, "R2 sdo word", got & mask, tx);
                        bread(2'd2, rd);
                        chk(rd == 16'h2, sg ? "R8 status after word" : "R3 R7 status after word", rd, 2);
                        bread(2'd0, rd);
                        chk(rd == mw, "R1 rx word", rd, mw);
                        chk(irq_cnt == i0 + 1, "R11 irq count", irq_cnt, i0 + 1);
                    end

        // R9: refused configuration leaves control unchanged.
        config_set(1'b0, 1'b0, 1'b0, 1'b0);
        bwrite(2'd1, 16'h0005);
        bread(2'd1, rd); chk(rd == 16'h0001, "R9 refused ctrl", rd, 16'h0001);

        // R7: transmit-full clears with no serial clock when gating is off.
        bwrite(2'd0, 16'h00A5); idle(4);
        bread(2'd2, rd); chk(rd[0] == 1'b0, "R7 tx_full after load", rd[0], 0);

        // R10: overflow on a second word without a read.
        i0 = irq_cnt;
        xfer(8, 16'h0033, 8, got);
        chk(got == 16'h00A5, "R10 first sdo", got, 16'h00A5);
        xfer(8, 16'h00C6, 8, got);
        bread(2'd2, rd); chk(rd == 16'h6, "R10 overflow status", rd, 6);
        bread(2'd0, rd); chk(rd == 16'h0033, "R10 first word kept", rd, 16'h0033);
        bread(2'd2, rd); chk(rd == 16'h4, "R10 overflow sticky", rd, 4);
        bwrite(2'd2, 16'h0004);
        bread(2'd2, rd); chk(rd == 16'h0, "R10 overflow cleared", rd, 0);
        chk(irq_cnt == i0 + 2, "R11 irq per word incl dropped", irq_cnt, i0 + 2);

        // R4: gated and select high: clock edges are ignored.
        config_set(1'b0, 1'b0, 1'b1, 1'b0);
        i0 = irq_cnt;
        bwrite(2'd0, 16'h003C); idle(6);
        chk(sdo_oe == 1'b0, "R5 oe with select high", sdo_oe, 0);
        xfer(8, 16'h0099, 8, got);
        bread(2'd2, rd); chk(rd == 16'h1, "R4 no word while deselected", rd, 1);
        chk(irq_cnt == i0, "R4 no irq while deselected", irq_cnt, i0);

        // R6/R8: partial word, abort, retry from the first bit.
        ss_n_pin = 1'b0; idle(6);
        chk(sdo_oe == 1'b1, "R5 oe with select low", sdo_oe, 1);
        xfer(5, 16'h0099, 8, got);
        chk(got == 16'h0007, "R6 first five bits", got, 7);
        bread(2'd2, rd); chk(rd == 16'h1, "R8 tx_full mid word", rd, 1);
        ss_n_pin = 1'b1; #1;
        chk(sdo_oe == 1'b0, "R5 oe released at once", sdo_oe, 0);
        idle(10);
        bread(2'd2, rd); chk(rd == 16'h1, "R6 R8 aborted word status", rd, 1);
        chk(irq_cnt == i0, "R6 no irq on abort", irq_cnt, i0);
        ss_n_pin = 1'b0; idle(6);
        xfer(8, 16'h0099, 8, got);
        ss_n_pin = 1'b1; idle(4);
        chk(got == 16'h003C, "R6 retried word", got, 16'h003C);
        bread(2'd2, rd); chk(rd == 16'h2, "R8 tx_full cleared after word", rd, 2);
        bread(2'd0, rd); chk(rd == 16'h0099, "R6 rx after retry", rd, 16'h0099);

        // R5: disabled block never drives data-out.
        ss_n_pin = 1'b0;
        bwrite(2'd1, 16'h0);
        #1 chk(sdo_oe == 1'b0, "R5 oe when disabled", sdo_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule